// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Engine

This block multiplies two operands and folds the product into one of four wide accumulator registers. It adds the product for an accumulate command and subtracts it for a subtract-accumulate command. A two-bit format code chooses how the operands are read: as signed integers, as unsigned integers or as signed fractions. Each completed operation updates three status flags: negative, zero and overflow. Every accumulator carries its own sticky overflow bit, and the overflow flag is taken from that bit, so an overflow stays visible until software reloads the accumulator.

The datapath spans four stages. In order they are operand capture, multiply, product alignment with product-overflow detection, and accumulation. Software loads an accumulator through a direct write port and reads it back through a read port. A read of an accumulator that still has an operation in flight is refused with a stall indication. Reads of any other accumulator are served at once.

Top module: `mac_pipe`

## Requirements
- R1: `op_fmt` selects the operand format. 2'b00 and 2'b11 mean signed two's-complement integer, 2'b01 means unsigned integer and 2'b10 means signed fraction. In both integer formats the product used is the low 40 bits of the full 64-bit product.
- R2: In fraction format a 32-bit operand holds one sign bit and 31 bits below the binary point. The product is doubled and its upper 32 bits are sign-extended to 40 bits. For example, 0x4000_0000 times 0x4000_0000 gives 0x00_2000_0000, and 0x8000_0000 times 0x8000_0000 gives 0x00_8000_0000.
- R3: An operation is accepted on the rising edge where `op_valid` is high. `op_sub`=0 adds the product and `op_sub`=1 subtracts it. The accumulator and the flags take the new value at the third rising edge after acceptance.
- R4: `flag_n` equals bit 39 and `flag_z` is high exactly when all 40 bits of the newest result are zero. Both change only when an operation completes.
- R5: A product overflow is raised when a signed integer product falls outside the 40-bit signed range, or when an unsigned integer product is 2^40 or more. Fraction products never raise it.
- R6: An accumulation overflow is raised when a signed sum falls outside the 40-bit signed range, or when an unsigned sum produces a carry or a borrow. The stored result wraps modulo 2^40.
- R7: Each accumulator has a sticky overflow bit. When an operation on an accumulator completes, that bit takes the OR of its old value, the product overflow and the accumulation overflow, and `flag_v` shows the new bit. Later operations never clear it.
- R8: `wr_en` loads `wr_data` into accumulator `wr_idx` at the next edge and clears that accumulator's sticky bit. If an operation on the same accumulator completes at the same edge, the write wins.
- R9: `rd_stall` is high when `rd_req` targets an accumulator that is named by an operation accepted in this cycle or in any of the three cycles before. A read issued the cycle after an operation therefore stalls for exactly three cycles. Otherwise `rd_valid` is high and `rd_data` holds the accumulator.
- R10: Operations in flight on other accumulators never stall a read.
- R11: After reset all accumulators, sticky bits and flags are zero and no read stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Issue a multiply-accumulate this cycle |
| op_sub | input | 1 | 1 subtracts the product, 0 adds it |
| op_fmt | input | 2 | Operand format code |
| op_idx | input | 2 | Target accumulator |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| wr_en | input | 1 | Direct accumulator load |
| wr_idx | input | 2 | Accumulator to load |
| wr_data | input | 40 | Load value |
| rd_req | input | 1 | Read request |
| rd_idx | input | 2 | Accumulator to read |
| rd_stall | output | 1 | Read refused, target busy |
| rd_valid | output | 1 | Read served this cycle |
| rd_data | output | 40 | Accumulator value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag (sticky per accumulator) |

## Verification
An accepted operation reaches its accumulator and the flags at the third rising edge after the edge that accepted it. The read stall and the read data are combinational and are due in the same cycle as the request. A reference model in the bench delays each operation through a three-slot queue and applies it at that third edge. Outputs are compared 1 ns after every falling edge, once the inputs for the cycle are stable and the edge's updates have settled. Directed reads wait until `rd_valid` and compare against hand-computed constants. They also count stall cycles to confirm the three-cycle interlock.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        FMT_SINT  = 2'b00,
        FMT_UINT  = 2'b01,
        FMT_SFRAC = 2'b10,
        FMT_SALT  = 2'b11
    } fmt_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult
    import mac_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  fmt_e                  fmt,
    input  logic [OP_W-1:0]       a,
    input  logic [OP_W-1:0]       b,
    output logic [2*OP_W-1:0]     prod
);
    localparam int PROD_W = 2 * OP_W;

    logic [PROD_W-1:0] ea, eb;

    // Extend to full product width; the low PROD_W bits of the product are exact.
    always_comb begin
        if (fmt == FMT_UINT) begin
            ea = {{OP_W{1'b0}}, a};
            eb = {{OP_W{1'b0}}, b};
        end else begin
            ea = {{OP_W{a[OP_W-1]}}, a};
            eb = {{OP_W{b[OP_W-1]}}, b};
        end
        prod = ea * eb;
    end
endmodule

// File: rtl/mac_align.sv
module mac_align
    import mac_pkg::*;
#(
    parameter int OP_W  = 32,
    parameter int ACC_W = 40
) (
    input  fmt_e                 fmt,
    input  logic [2*OP_W-1:0]    prod,
    output logic [ACC_W-1:0]     p,
    output logic                 povf
);
    localparam int PROD_W = 2 * OP_W;
    localparam int EXT_W  = ACC_W - OP_W - 1;

    always_comb begin
        case (fmt)
            FMT_UINT: begin
                p    = prod[ACC_W-1:0];
                povf = |prod[PROD_W-1:ACC_W];
            end
            FMT_SFRAC: begin
                // doubled product, upper half kept, sign-extended
                p    = {{EXT_W{prod[PROD_W-1]}}, prod[PROD_W-1:OP_W-1]};
                povf = 1'b0;
            end
            default: begin
                p    = prod[ACC_W-1:0];
                povf = !((&prod[PROD_W-1:ACC_W-1]) || !(|prod[PROD_W-1:ACC_W-1]));
            end
        endcase
    end
endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
#(
    parameter int ACC_W = 40
) (
    input  fmt_e               fmt,
    input  logic               sub,
    input  logic [ACC_W-1:0]   acc_in,
    input  logic [ACC_W-1:0]   p,
    output logic [ACC_W-1:0]   res,
    output logic               aovf
);
    logic [ACC_W:0] xa, xp, r;

    always_comb begin
        if (fmt == FMT_UINT) begin
            xa = {1'b0, acc_in};
            xp = {1'b0, p};
        end else begin
            xa = {acc_in[ACC_W-1], acc_in};
            xp = {p[ACC_W-1], p};
        end
        r    = sub ? (xa - xp) : (xa + xp);
        res  = r[ACC_W-1:0];
        aovf = (fmt == FMT_UINT) ? r[ACC_W] : (r[ACC_W] ^ r[ACC_W-1]);
    end
endmodule

// File: rtl/mac_pipe.sv
module mac_pipe
    import mac_pkg::*;
#(
    parameter int OP_W  = 32,
    parameter int ACC_W = 40,
    parameter int N_ACC = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      op_valid,
    input  logic                      op_sub,
    input  logic [1:0]                op_fmt,
    input  logic [$clog2(N_ACC)-1:0]  op_idx,
    input  logic [OP_W-1:0]           op_a,
    input  logic [OP_W-1:0]           op_b,
    input  logic                      wr_en,
    input  logic [$clog2(N_ACC)-1:0]  wr_idx,
    input  logic [ACC_W-1:0]          wr_data,
    input  logic                      rd_req,
    input  logic [$clog2(N_ACC)-1:0]  rd_idx,
    output logic                      rd_stall,
    output logic                      rd_valid,
    output logic [ACC_W-1:0]          rd_data,
    output logic                      flag_n,
    output logic                      flag_z,
    output logic                      flag_v
);
    localparam int IDX_W  = $clog2(N_ACC);
    localparam int PROD_W = 2 * OP_W;

    typedef struct packed {
        logic             vld;
        logic             sub;
        fmt_e             fmt;
        logic [IDX_W-1:0] idx;
        logic [OP_W-1:0]  a;
        logic [OP_W-1:0]  b;
    } cap_t;

    typedef struct packed {
        logic              vld;
        logic              sub;
        fmt_e              fmt;
        logic [IDX_W-1:0]  idx;
        logic [PROD_W-1:0] prod;
    } mul_t;

    typedef struct packed {
        logic             vld;
        logic             sub;
        fmt_e             fmt;
        logic [IDX_W-1:0] idx;
        logic [ACC_W-1:0] p;
        logic             povf;
    } aln_t;

    typedef struct packed {
        cap_t                         s1;
        mul_t                         s2;
        aln_t                         s3;
        logic [N_ACC-1:0][ACC_W-1:0]  acc;
        logic [N_ACC-1:0]             sticky;
        logic                         n;
        logic                         z;
        logic                         v;
    } state_t;

    state_t r_d, r_q;

    logic [PROD_W-1:0] mul_prod;
    logic [ACC_W-1:0]  aln_p;
    logic              aln_ovf;
    logic [ACC_W-1:0]  sum_res;
    logic              sum_ovf;
    logic [N_ACC-1:0]  busy;
    logic              sticky_new;
    logic              done_vld;
    logic [N_ACC-1:0]  sticky_vec;

    mac_mult #(.OP_W(OP_W)) u_mult (
        .fmt  (r_q.s1.fmt),
        .a    (r_q.s1.a),
        .b    (r_q.s1.b),
        .prod (mul_prod)
    );

    mac_align #(.OP_W(OP_W), .ACC_W(ACC_W)) u_align (
        .fmt  (r_q.s2.fmt),
        .prod (r_q.s2.prod),
        .p    (aln_p),
        .povf (aln_ovf)
    );

    mac_accum #(.ACC_W(ACC_W)) u_accum (
        .fmt    (r_q.s3.fmt),
        .sub    (r_q.s3.sub),
        .acc_in (r_q.acc[r_q.s3.idx]),
        .p      (r_q.s3.p),
        .res    (sum_res),
        .aovf   (sum_ovf)
    );

    // Busy: target of an op in the issue cycle or any of the three stages
    for (genvar k = 0; k < N_ACC; k++) begin : g_busy
        assign busy[k] = (op_valid   && op_idx     == IDX_W'(k)) ||
                         (r_q.s1.vld && r_q.s1.idx == IDX_W'(k)) ||
                         (r_q.s2.vld && r_q.s2.idx == IDX_W'(k)) ||
                         (r_q.s3.vld && r_q.s3.idx == IDX_W'(k));
    end

    always_comb begin
        r_d = r_q;

        r_d.s1.vld = op_valid;
        r_d.s1.sub = op_sub;
        r_d.s1.fmt = fmt_e'(op_fmt);
        r_d.s1.idx = op_idx;
        r_d.s1.a   = op_a;
        r_d.s1.b   = op_b;

        r_d.s2.vld  = r_q.s1.vld;
        r_d.s2.sub  = r_q.s1.sub;
        r_d.s2.fmt  = r_q.s1.fmt;
        r_d.s2.idx  = r_q.s1.idx;
        r_d.s2.prod = mul_prod;

        r_d.s3.vld  = r_q.s2.vld;
        r_d.s3.sub  = r_q.s2.sub;
        r_d.s3.fmt  = r_q.s2.fmt;
        r_d.s3.idx  = r_q.s2.idx;
        r_d.s3.p    = aln_p;
        r_d.s3.povf = aln_ovf;

        sticky_new = r_q.sticky[r_q.s3.idx] | r_q.s3.povf | sum_ovf;
        if (r_q.s3.vld) begin
            r_d.acc[r_q.s3.idx]    = sum_res;
            r_d.sticky[r_q.s3.idx] = sticky_new;
            r_d.n = sum_res[ACC_W-1];
            r_d.z = (sum_res == '0);
            r_d.v = sticky_new;
        end

        // direct load wins over a completing operation
        if (wr_en) begin
            r_d.acc[wr_idx]    = wr_data;
            r_d.sticky[wr_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_stall   = rd_req &&  busy[rd_idx];
    assign rd_valid   = rd_req && !busy[rd_idx];
    assign rd_data    = r_q.acc[rd_idx];
    assign flag_n     = r_q.n;
    assign flag_z     = r_q.z;
    assign flag_v     = r_q.v;
    assign done_vld   = r_q.s3.vld;
    assign sticky_vec = r_q.sticky;
endmodule

// File: rtl/mac_pipe_chk.sv
module mac_pipe_chk #(
    parameter int IDX_W = 2,
    parameter int N_ACC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [IDX_W-1:0] op_idx,
    input logic             rd_req,
    input logic [IDX_W-1:0] rd_idx,
    input logic             rd_stall,
    input logic             rd_valid,
    input logic             wr_en,
    input logic             flag_n,
    input logic             flag_z,
    input logic             flag_v,
    input logic             done_vld,
    input logic [N_ACC-1:0] sticky
);
    AST_SAME_CYCLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && rd_req && rd_idx == op_idx) |-> rd_stall); // R9

    AST_STALL_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && $past(op_valid) && rd_idx == $past(op_idx)) |-> rd_stall); // R9

    AST_READ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || rd_stall) |-> (rd_req && !(rd_valid && rd_stall))); // R9

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_vld |=> $stable({flag_n, flag_z, flag_v})); // R4

    AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        flag_z |-> !flag_n); // R4

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(sticky) & ~sticky)) |-> $past(wr_en)); // R7
endmodule

bind mac_pipe mac_pipe_chk #(.IDX_W(IDX_W), .N_ACC(N_ACC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_idx   (op_idx),
    .rd_req   (rd_req),
    .rd_idx   (rd_idx),
    .rd_stall (rd_stall),
    .rd_valid (rd_valid),
    .wr_en    (wr_en),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_v   (flag_v),
    .done_vld (done_vld),
    .sticky   (sticky_vec)
);

// File: tb/mac_pipe_bench.sv
`timescale 1ns/1ps
module mac_pipe_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_sub = 1'b0;
    logic [1:0]  op_fmt = 2'b00, op_idx = 2'b00;
    logic [31:0] op_a = '0, op_b = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = 2'b00;
    logic [39:0] wr_data = '0;
    logic        rd_req = 1'b0;
    logic [1:0]  rd_idx = 2'b00;
    logic        rd_stall, rd_valid, flag_n, flag_z, flag_v;
    logic [39:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    mac_pipe u_mac_pipe (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op_valid), .op_sub(op_sub), .op_fmt(op_fmt), .op_idx(op_idx),
        .op_a(op_a), .op_b(op_b),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_req(rd_req), .rd_idx(rd_idx),
        .rd_stall(rd_stall), .rd_valid(rd_valid), .rd_data(rd_data),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct packed {
        logic        vld;
        logic        sub;
        logic [1:0]  fmt;
        logic [1:0]  idx;
        logic [31:0] a;
        logic [31:0] b;
    } pend_t;

    pend_t       pq [3];
    logic [39:0] m_acc [4];
    logic        m_stk [4];
    logic        m_n, m_z, m_v;

    localparam logic signed [127:0] S_MAX = (128'sd1 <<< 39) - 1;
    localparam logic signed [127:0] S_MIN = -(128'sd1 <<< 39);
    localparam logic signed [127:0] U_LIM = (128'sd1 <<< 40);

    task automatic model_apply(input pend_t o);
        logic signed [127:0] pr, av, pv, r;
        logic povf, aovf;
        logic [39:0] p40;
        if (o.fmt == 2'b01) begin
            pr   = $signed({96'b0, o.a}) * $signed({96'b0, o.b});
            povf = (pr >= U_LIM);
        end else if (o.fmt == 2'b10) begin
            pr   = ($signed({{96{o.a[31]}}, o.a}) * $signed({{96{o.b[31]}}, o.b})) >>> 31;
            povf = 1'b0;
        end else begin
            pr   = $signed({{96{o.a[31]}}, o.a}) * $signed({{96{o.b[31]}}, o.b});
            povf = (pr > S_MAX) || (pr < S_MIN);
        end
        p40 = pr[39:0];
        if (o.fmt == 2'b01) begin
            av = $signed({88'b0, m_acc[o.idx]});
            pv = $signed({88'b0, p40});
        end else begin
            av = $signed({{88{m_acc[o.idx][39]}}, m_acc[o.idx]});
            pv = $signed({{88{p40[39]}}, p40});
        end
        r = o.sub ? av - pv : av + pv;
        if (o.fmt == 2'b01) aovf = (r < 0) || (r >= U_LIM);
        else                aovf = (r > S_MAX) || (r < S_MIN);
        m_acc[o.idx] = r[39:0];
        m_stk[o.idx] = m_stk[o.idx] | povf | aovf;
        m_n = r[39];
        m_z = (r[39:0] == 40'd0);
        m_v = m_stk[o.idx];
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) pq[i] = '0;
            for (int i = 0; i < 4; i++) begin m_acc[i] = '0; m_stk[i] = 1'b0; end
            m_n = 1'b0; m_z = 1'b0; m_v = 1'b0;
        end else begin
            if (pq[2].vld) model_apply(pq[2]);
            if (wr_en) begin m_acc[wr_idx] = wr_data; m_stk[wr_idx] = 1'b0; end
            pq[2] = pq[1];
            pq[1] = pq[0];
            pq[0] = {op_valid, op_sub, op_fmt, op_idx, op_a, op_b};
        end
    end

    function automatic logic m_busy(input logic [1:0] k);
        logic b;
        b = op_valid && op_idx == k;
        for (int i = 0; i < 3; i++) b = b || (pq[i].vld && pq[i].idx == k);
        return b;
    endfunction

    // per-cycle comparison, 1 ns after the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            #1;
            begin
                logic eb;
                eb = rd_req && m_busy(rd_idx);
                chk((rd_req && !eb) ? "R10" : "R9", "rd_stall", {63'b0, rd_stall}, {63'b0, eb});
                chk("R9", "rd_valid", {63'b0, rd_valid}, {63'b0, rd_req && !eb});
                if (rd_req && !eb) chk("R3", "rd_data", {24'b0, rd_data}, {24'b0, m_acc[rd_idx]});
                chk("R4", "flags_nz", {62'b0, flag_n, flag_z}, {62'b0, m_n, m_z});
                chk("R7", "flag_v", {63'b0, flag_v}, {63'b0, m_v});
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle();
        @(negedge clk);
        op_valid = 0; wr_en = 0; rd_req = 0;
    endtask

    task automatic issue(input logic sub, input logic [1:0] fmt, input logic [1:0] idx,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        wr_en = 0; rd_req = 0;
        op_valid = 1; op_sub = sub; op_fmt = fmt; op_idx = idx; op_a = a; op_b = b;
    endtask

    task automatic load(input logic [1:0] idx, input logic [39:0] d);
        @(negedge clk);
        op_valid = 0; rd_req = 0;
        wr_en = 1; wr_idx = idx; wr_data = d;
    endtask

    // read until served; returns number of stalled cycles
    task automatic rd_wait(input logic [1:0] idx, input logic [39:0] exp,
                           input string tag, output int stalls);
        stalls = 0;
        for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            op_valid = 0; wr_en = 0;
            rd_req = 1; rd_idx = idx;
            #1;
            if (rd_valid) break;
            stalls++;
        end
        chk(tag, "acc_value", {24'b0, rd_data}, {24'b0, exp});
    endtask

    task automatic flags(input logic n, input logic z, input logic v, input string tag);
        chk(tag, "nzv", {61'b0, flag_n, flag_z, flag_v}, {61'b0, n, z, v});
    endtask

    initial begin
        int st;
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R11 actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int st;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R11: reset state
        for (int k = 0; k < 4; k++) rd_wait(2'(k), 40'd0, "R11", st);
        flags(0, 0, 0, "R11");

        // R3 / R9: add, then a read right behind it stalls three cycles
        issue(0, 2'b00, 2'd0, 32'd3, 32'd4);
        rd_wait(2'd0, 40'd12, "R3", st);
        chk("R9", "stall_cycles", 64'(st), 64'd3);
        issue(1, 2'b00, 2'd0, 32'hFFFF_FFFB, 32'd7);      // minus (-5*7)
        rd_wait(2'd0, 40'd47, "R3", st);
        flags(0, 0, 0, "R4");
        issue(1, 2'b11, 2'd0, 32'd47, 32'd1);             // alternate signed code
        rd_wait(2'd0, 40'd0, "R4", st);
        flags(0, 1, 0, "R4");
        issue(1, 2'b00, 2'd0, 32'd1, 32'd1);
        rd_wait(2'd0, 40'hFF_FFFF_FFFF, "R4", st);
        flags(1, 0, 0, "R4");

        // R1: unsigned versus signed interpretation of the same bits
        load(2'd1, 40'd0);
        load(2'd2, 40'd0);
        issue(0, 2'b01, 2'd1, 32'hFFFF_FFFF, 32'd255);
        issue(0, 2'b00, 2'd2, 32'hFFFF_FFFF, 32'd255);
        rd_wait(2'd1, 40'hFE_FFFF_FF01, "R1", st);
        rd_wait(2'd2, 40'hFF_FFFF_FF01, "R1", st);

        // R2: fractional products
        load(2'd3, 40'd0);
        issue(0, 2'b10, 2'd3, 32'h4000_0000, 32'h4000_0000);
        rd_wait(2'd3, 40'h00_2000_0000, "R2", st);
        issue(0, 2'b10, 2'd3, 32'h8000_0000, 32'h8000_0000);
        rd_wait(2'd3, 40'h00_A000_0000, "R2", st);
        flags(0, 0, 0, "R2");

        // R5 / R7 / R8: product overflow and sticky behaviour
        load(2'd1, 40'd0);
        issue(0, 2'b00, 2'd1, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        rd_wait(2'd1, 40'hFF_0000_0001, "R5", st);
        flags(1, 0, 1, "R5");
        issue(0, 2'b00, 2'd1, 32'd1, 32'd1);
        rd_wait(2'd1, 40'hFF_0000_0002, "R7", st);
        flags(1, 0, 1, "R7");
        issue(0, 2'b00, 2'd2, 32'd1, 32'd1);
        rd_wait(2'd2, 40'hFF_FFFF_FF02, "R7", st);
        flags(1, 0, 0, "R7");
        load(2'd1, 40'd0);
        issue(0, 2'b00, 2'd1, 32'd1, 32'd1);
        rd_wait(2'd1, 40'd1, "R8", st);
        flags(0, 0, 0, "R8");
        load(2'd0, 40'd0);
        issue(0, 2'b01, 2'd0, 32'h0010_0000, 32'h0010_0000);
        rd_wait(2'd0, 40'd0, "R5", st);
        flags(0, 1, 1, "R5");

        // R6: accumulation overflow, signed and unsigned
        load(2'd2, 40'h7F_FFFF_FFFF);
        issue(0, 2'b00, 2'd2, 32'd1, 32'd1);
        rd_wait(2'd2, 40'h80_0000_0000, "R6", st);
        flags(1, 0, 1, "R6");
        load(2'd3, 40'd0);
        issue(1, 2'b01, 2'd3, 32'd1, 32'd1);
        rd_wait(2'd3, 40'hFF_FFFF_FFFF, "R6", st);
        flags(1, 0, 1, "R6");

        // R10: read of another accumulator is not held back
        issue(0, 2'b00, 2'd0, 32'd2, 32'd2);
        rd_wait(2'd1, 40'd1, "R10", st);
        chk("R10", "stall_cycles", 64'(st), 64'd0);
        idle(); idle(); idle();

        // R9: op and read on the same accumulator in one cycle
        @(negedge clk);
        wr_en = 0;
        op_valid = 1; op_sub = 0; op_fmt = 2'b00; op_idx = 2'd2; op_a = 32'd1; op_b = 32'd1;
        rd_req = 1; rd_idx = 2'd2;
        #1 chk("R9", "same_cycle_stall", {63'b0, rd_stall}, 64'd1);
        idle(); idle(); idle(); idle();

        // R8: load wins over a completing operation
        load(2'd0, 40'd0);
        issue(0, 2'b00, 2'd0, 32'd1, 32'd1);
        idle(); idle();
        load(2'd0, 40'h55);
        rd_wait(2'd0, 40'h55, "R8", st);

        // mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            op_valid = ($urandom % 3) != 0;
            op_sub   = 1'($urandom);
            op_fmt   = 2'($urandom);
            op_idx   = 2'($urandom);
            op_a     = $urandom;
            op_b     = (($urandom % 4) == 0) ? $urandom : ($urandom % 1000);
            wr_en    = ($urandom % 8) == 0;
            wr_idx   = 2'($urandom);
            wr_data  = {8'($urandom), 32'($urandom)};
            rd_req   = 1'($urandom);
            rd_idx   = 2'($urandom);
        end
        idle(); idle(); idle(); idle(); idle();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule